// File: doc/BRIEF.md
# UART Receive Interrupt Identification

This block sits beside a UART receiver and its receive FIFO. It watches the FIFO fill level supplied by the FIFO controller and compares it with a programmable trigger level. It also runs a character-timeout timer that advances on a per-bit baud tick. From these two receive conditions it builds a 4-bit interrupt identification code, an interrupt request output and a receive-ready status output.

The two receive conditions share one priority level. They are merged by ORing their identification bits. Bit 2 marks "receive data needs service" and is set by either condition. Bit 3 is set only by the timeout. As a result, a pending timeout always shows as the timeout code, even when the trigger level has also been reached. This holds even if the trigger code was already on the output.

Host software clears either condition by reading the receive holding register. The block sees that read as a one-cycle strobe. The timer restarts on every received character and on every host read, and it runs only while the FIFO holds data.

Top module: `rx_irq_ident`

## Requirements
- R1: After synchronous reset, `int_id` is 4'b0001 (none pending) and `irq_active` and `rx_ready` are 0.
- R2: When `trig_level` is nonzero and `fifo_count >= trig_level`, with no timeout pending, `int_id` is 4'b0100 in the same cycle. It stays at that code while the count is at or above the level.
- R3: When `fifo_count < trig_level` and no timeout is pending, `int_id` is 4'b0001.
- R4: With the FIFO non-empty and no character or read strobe, a timeout becomes pending on the baud tick that completes the window. `int_id` reads 4'b1100 right after that clock edge and not before.
- R5: A `char_in` strobe restarts the timer. A full window of ticks counted from that strobe is needed before a timeout is raised.
- R6: An `rhr_read` strobe clears a pending timeout at the next edge and restarts the timer.
- R7: When both conditions are pending, `int_id` is 4'b1100. Bit 3 (timeout) is ORed over bit 2 (trigger).
- R8: `irq_active` and `rx_ready` are 1 exactly when `int_id` is not 4'b0001.
- R9: While `fifo_count` is 0, the timer does not advance, and any pending timeout is cleared at the next edge.
- R10: The window length in ticks is 4 × (data bits + 3). `char_len` encodes 0..3 as 5..8 data bits, which gives 32, 36, 40 or 44 ticks.
- R11: A `trig_level` of 0 never raises the trigger condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| char_in | input | 1 | Strobe: a character was written into the FIFO |
| rhr_read | input | 1 | Strobe: host read of the receive holding register |
| fifo_count | input | 7 | Current FIFO fill level |
| trig_level | input | 7 | Programmed trigger level, 0 disables |
| char_len | input | 2 | Data bits minus 5 |
| int_id | output | 4 | Interrupt identification code |
| irq_active | output | 1 | Interrupt request |
| rx_ready | output | 1 | Receive data needs service |

## Verification
The trigger path is combinational, so the bench samples the trigger code on the same falling edge at which it drives the FIFO count. Timeout results come one rising edge after the deciding tick or strobe. The bench drives every stimulus on a falling edge and checks at the following falling edge, so every registered result is sampled exactly one edge after its cause. For each character length, the window is checked by confirming the code is still clear after window−1 ticks and is the timeout code after the next tick.

// File: rtl/rx_irq_pkg.sv
// Package: shared identification codes and window arithmetic for the
// receive interrupt identification block.
package rx_irq_pkg;
    localparam logic [3:0] ID_NONE    = 4'b0001;
    localparam logic [3:0] ID_TRIGGER = 4'b0100;
    localparam logic [3:0] ID_TIMEOUT = 4'b1100;

    localparam int MIN_DATA_BITS = 5;

    // Window length in ticks for a given char_len code.
    function automatic int unsigned window_ticks(input logic [1:0] len,
                                                 input int unsigned chars,
                                                 input int unsigned extra);
        return chars * (MIN_DATA_BITS + int'(len) + extra);
    endfunction
endpackage

// File: rtl/rx_trig_cmp.sv
// Module: rx_trig_cmp
// Compares the FIFO fill level against the programmed trigger level.
// Assumes fifo_count is already synchronous to clk. A zero level disables
// the comparison. The output is combinational.
module rx_trig_cmp #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_count,
    input  logic [LVL_W-1:0] trig_level,
    output logic             trig_hit
);
    // Purpose: raise the trigger condition while the count is at or above the level.
    always_comb begin
        trig_hit = (trig_level != '0) && (fifo_count >= trig_level);
    end

    // R11: a zero level never produces a hit
    p_zero_level_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_level == '0) |-> !trig_hit);
endmodule

// File: rtl/rx_char_timer.sv
// Module: rx_char_timer
// Character-timeout timer. Counts baud ticks while the FIFO holds data.
// Restarts on each received character and each host read. Raises a sticky
// timeout flag when the window completes; the flag is cleared by a host read
// or by the FIFO going empty. Assumes baud_tick is a single-cycle pulse.
module rx_char_timer #(
    parameter int LVL_W       = 7,
    parameter int WIN_CHARS   = 4,
    parameter int FRAME_EXTRA = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             char_in,
    input  logic             rhr_read,
    input  logic [LVL_W-1:0] fifo_count,
    input  logic [1:0]       char_len,
    output logic             to_pend
);
    import rx_irq_pkg::*;

    localparam int MAX_TICKS = WIN_CHARS * (MIN_DATA_BITS + 3 + FRAME_EXTRA);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] limit;
    logic             fifo_empty;
    logic             restart;
    logic             fire;

    // Purpose: derive the window limit from the character length.
    always_comb begin
        limit = CNT_W'(window_ticks(char_len, WIN_CHARS, FRAME_EXTRA));
    end

    // Purpose: decode restart and the completing tick.
    always_comb begin
        fifo_empty = (fifo_count == '0);
        restart    = char_in || rhr_read || fifo_empty;
        fire       = baud_tick && !restart && (tick_cnt == limit - 1'b1);
    end

    // Purpose: advance the tick counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (restart)
            tick_cnt <= '0;
        else if (baud_tick && (tick_cnt < limit))
            tick_cnt <= tick_cnt + 1'b1;
    end

    // Purpose: hold the timeout flag until a host read or the FIFO empties.
    always_ff @(posedge clk) begin
        if (!rst_n)
            to_pend <= 1'b0;
        else if (rhr_read || fifo_empty)
            to_pend <= 1'b0;
        else if (fire)
            to_pend <= 1'b1;
    end

    // R6: a host read clears a pending timeout at the next edge
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rhr_read |=> !to_pend);
    // R5: a received character restarts the count
    p_char_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        char_in |=> (tick_cnt == '0));
    // R9: an empty FIFO leaves no timeout pending
    p_empty_no_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |=> !to_pend);
    // R10: the count never passes the window limit
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= CNT_W'(MAX_TICKS));
endmodule

// File: rtl/rx_id_merge.sv
// Module: rx_id_merge
// Merges the two receive conditions at one priority level by ORing their
// identification bits. A timeout therefore always reads as the timeout code.
// Both status outputs follow "any receive condition pending".
module rx_id_merge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_hit,
    input  logic       to_pend,
    output logic [3:0] int_id,
    output logic       irq_active,
    output logic       rx_ready
);
    import rx_irq_pkg::*;

    logic any_rx;

    // Purpose: form the identification code from the OR of both sources.
    always_comb begin
        any_rx     = trig_hit | to_pend;
        int_id     = {to_pend, any_rx, 1'b0, ~any_rx};
        irq_active = any_rx;
        rx_ready   = any_rx;
    end

    // R7: a pending timeout is always reported as the timeout code
    p_timeout_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        to_pend |-> (int_id == ID_TIMEOUT));
    // R8: the code is always one of the three legal values
    p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id == ID_NONE) || (int_id == ID_TRIGGER) || (int_id == ID_TIMEOUT));
    // R2: a trigger hit alone gives the trigger code
    p_trigger_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !to_pend) |-> (int_id == ID_TRIGGER));
endmodule

// File: rtl/rx_irq_ident.sv
// Module: rx_irq_ident (top)
// Receive interrupt identification: trigger-level comparison, character
// timeout timer, and OR-merge of the two into one identification code.
// Assumes all inputs are synchronous to clk and strobes last one cycle.
module rx_irq_ident #(
    parameter int LVL_W       = 7,
    parameter int WIN_CHARS   = 4,
    parameter int FRAME_EXTRA = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             char_in,
    input  logic             rhr_read,
    input  logic [LVL_W-1:0] fifo_count,
    input  logic [LVL_W-1:0] trig_level,
    input  logic [1:0]       char_len,
    output logic [3:0]       int_id,
    output logic             irq_active,
    output logic             rx_ready
);
    logic trig_hit;
    logic to_pend;

    rx_trig_cmp #(.LVL_W(LVL_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_count (fifo_count),
        .trig_level (trig_level),
        .trig_hit   (trig_hit)
    );

    rx_char_timer #(
        .LVL_W       (LVL_W),
        .WIN_CHARS   (WIN_CHARS),
        .FRAME_EXTRA (FRAME_EXTRA)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .char_in    (char_in),
        .rhr_read   (rhr_read),
        .fifo_count (fifo_count),
        .char_len   (char_len),
        .to_pend    (to_pend)
    );

    rx_id_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_hit   (trig_hit),
        .to_pend    (to_pend),
        .int_id     (int_id),
        .irq_active (irq_active),
        .rx_ready   (rx_ready)
    );
endmodule

// File: tb/rx_irq_ident_test.sv
// Bench for rx_irq_ident: sweeps trigger levels against fill levels and
// every character length against its timeout window.
module rx_irq_ident_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       char_in = 1'b0;
    logic       rhr_read = 1'b0;
    logic [6:0] fifo_count = '0;
    logic [6:0] trig_level = '0;
    logic [1:0] char_len = '0;
    logic [3:0] int_id;
    logic       irq_active;
    logic       rx_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_irq_ident uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .char_in(char_in),
        .rhr_read(rhr_read), .fifo_count(fifo_count), .trig_level(trig_level),
        .char_len(char_len), .int_id(int_id), .irq_active(irq_active),
        .rx_ready(rx_ready)
    );

    task automatic check_id(input logic [3:0] exp, input string req);
        checks++;
        if (int_id !== exp) begin
            errors++;
            $display("FAIL %s: int_id=%b expected %b", req, int_id, exp);
        end
        checks++;
        if (irq_active !== (exp != 4'b0001) || rx_ready !== (exp != 4'b0001)) begin
            errors++;
            $display("FAIL R8: irq=%b rdy=%b expected %b", irq_active, rx_ready,
                     exp != 4'b0001);
        end
    endtask

    // One clock with the given strobes; returns at the next falling edge.
    task automatic step(input logic tk, input logic ch, input logic rd);
        @(negedge clk);
        baud_tick = tk; char_in = ch; rhr_read = rd;
        @(negedge clk);
        baud_tick = 1'b0; char_in = 1'b0; rhr_read = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_id(4'b0001, "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);
        check_id(4'b0001, "R1");

        // R2 R3 R11: trigger sweep, combinational, no timeout pending
        for (int lvl = 0; lvl <= 8; lvl++) begin
            for (int cnt = 0; cnt <= 9; cnt++) begin
                @(negedge clk);
                trig_level = 7'(lvl);
                fifo_count = 7'(cnt);
                #1;
                if (lvl == 0) check_id(4'b0001, "R11");
                else if (cnt >= lvl) check_id(4'b0100, "R2");
                else check_id(4'b0001, "R3");
            end
        end

        // R4 R10 R6 R7: timeout window per character length
        for (int len = 0; len < 4; len++) begin
            int win;
            win = 4 * (5 + len + 3);
            @(negedge clk);
            char_len = 2'(len);
            trig_level = 7'd4;
            fifo_count = 7'd3;
            step(1'b0, 1'b0, 1'b1);
            check_id(4'b0001, "R6");
            ticks(win - 1);
            check_id(4'b0001, "R10");
            ticks(1);
            check_id(4'b1100, "R4");
            step(1'b0, 1'b0, 1'b1);
            check_id(4'b0001, "R6");
            // both pending: count above level while timeout raised
            ticks(win);
            fifo_count = 7'd5;
            #1;
            check_id(4'b1100, "R7");
            step(1'b0, 1'b0, 1'b1);
            check_id(4'b0100, "R2");
        end

        // R5: character strobe restarts the window (len 3, 44 ticks)
        @(negedge clk);
        fifo_count = 7'd2;
        step(1'b0, 1'b0, 1'b1);
        ticks(30);
        step(1'b0, 1'b1, 1'b0);
        ticks(43);
        check_id(4'b0001, "R5");
        ticks(1);
        check_id(4'b1100, "R5");

        // R9: empty FIFO clears timeout and stops counting
        @(negedge clk);
        fifo_count = 7'd0;
        step(1'b0, 1'b0, 1'b0);
        check_id(4'b0001, "R9");
        ticks(60);
        check_id(4'b0001, "R9");
        @(negedge clk);
        fifo_count = 7'd1;
        ticks(43);
        check_id(4'b0001, "R9");
        ticks(1);
        check_id(4'b1100, "R4");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule